// File: doc/BRIEF.md
# Bidirectional serial-in polarity row driver

This block is the logic core of a row driver for a matrix display. A slow serial shift clock moves data, one bit per falling edge, into a register with one stage per row. A direction input sets which way the bits travel. It also sets which end of the register appears on the serial output, so several cores can be chained in either scan order. A design can reverse the scan at run time just by flipping that input.

Each row output is three-state and is given as two bits: a drive enable and a drive level. When the global enable is high, a row whose stage holds 1 is driven to the rail chosen by the polarity input, and a row holding 0 floats. When the enable is low, every row floats. Because the level bit follows polarity for all rows, alternating the polarity from frame to frame gives symmetric drive of the selected rows. The shift clock is sampled by the system clock `clk_i`, and a falling edge is acted on at the first rising edge of `clk_i` that sees the shift clock low after it was high.

Top module: `row_drv_core`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the register is all zero: every `drv_en_o` bit is 0 and `dout_o` is 0. A shift clock that is low at release causes no shift.
- R2: The register changes only when a falling edge of `sclk_i` is detected, at the first `clk_i` rising edge that sees `sclk_i` low after it was high. Holding `sclk_i` high or low for any time, or changing `din_i` at any time away from that edge, leaves all outputs unchanged.
- R3: With `dir_i` = 0, a detected falling edge loads `din_i` into row 0 and moves row k-1 into row k for k = 1..N_ROWS-1.
- R4: With `dir_i` = 1, a detected falling edge loads `din_i` into row N_ROWS-1 and moves row k+1 into row k for k = 0..N_ROWS-2.
- R5: `dout_o` shows row N_ROWS-1 when `dir_i` = 0 and row 0 when `dir_i` = 1. The tap follows `dir_i` at once, with no shift needed.
- R6: With `en_i` = 1, `drv_en_o[k]` equals the stored bit of row k, so a 0 row floats. `lvl_o` equals `pol_i` on every bit, for both values of `pol_i`.
- R7: With `en_i` = 0, all `drv_en_o` bits are 0 whatever the register holds and whatever `pol_i` is. Shifting continues while the enable is low, and the stored pattern reappears on `drv_en_o` once `en_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock; the register acts on its falling edge |
| din_i | input | 1 | Serial data input |
| dir_i | input | 1 | Shift direction: 0 moves data toward row N_ROWS-1, 1 moves it toward row 0 |
| pol_i | input | 1 | Polarity: the level that selected rows are driven to |
| en_i | input | 1 | Global output enable |
| dout_o | output | 1 | Serial cascade output, taken from the end that `dir_i` selects |
| drv_en_o | output | N_ROWS | Per-row drive enable; 0 means the row floats |
| lvl_o | output | N_ROWS | Per-row drive level |

## Verification
An irregular arithmetic bit stream is shifted through the full length in each direction. After every edge the whole row vector and the cascade tap are compared with a bench model. This shows whether the shift goes the right way, whether new data enters at the right end, and whether the tap sits at the right end. The shift clock is then held high and held low while the data input toggles, which tells a true falling-edge detector apart from one that acts on level or on data changes. All four combinations of enable and polarity are swept over a mixed pattern, so a stored 1 and a stored 0 are each seen under both polarities and under the enable override. Shifting while the enable is low, and then enabling again, shows that the enable gates only the outputs and leaves the register free to load.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic {
    SHIFT_UP = 1'b0,
    SHIFT_DN = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/rdc_edge_det.sv
module rdc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o
);
  logic sclk_q;

  // reset low: an edge needs a high level seen after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/rdc_shift_reg.sv
module rdc_shift_reg #(
  parameter int unsigned N_ROWS = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  rdc_pkg::shift_dir_e dir_i,
  input  logic              din_i,
  output logic [N_ROWS-1:0] q_o
);
  localparam int unsigned LAST = N_ROWS - 1;

  logic [N_ROWS-1:0] q;
  logic [N_ROWS-1:0] nxt;

  for (genvar k = 0; k < N_ROWS; k++) begin : g_stage
    logic from_low, from_high;
    if (k == 0) begin : g_first
      assign from_low = din_i;
    end else begin : g_mid_lo
      assign from_low = q[k-1];
    end
    if (k == LAST) begin : g_last
      assign from_high = din_i;
    end else begin : g_mid_hi
      assign from_high = q[k+1];
    end
    assign nxt[k] = (dir_i == rdc_pkg::SHIFT_DN) ? from_high : from_low;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (shift_i) q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/rdc_out_stage.sv
module rdc_out_stage #(
  parameter int unsigned N_ROWS = 34
) (
  input  logic [N_ROWS-1:0]   q_i,
  input  rdc_pkg::shift_dir_e dir_i,
  input  logic                pol_i,
  input  logic                en_i,
  output logic                dout_o,
  output logic [N_ROWS-1:0]   drv_en_o,
  output logic [N_ROWS-1:0]   lvl_o
);
  assign drv_en_o = q_i & {N_ROWS{en_i}};
  assign lvl_o    = {N_ROWS{pol_i}};
  // cascade tap sits at the end data moves toward
  assign dout_o   = (dir_i == rdc_pkg::SHIFT_DN) ? q_i[0] : q_i[N_ROWS-1];
endmodule

// File: rtl/row_drv_core.sv
module row_drv_core #(
  parameter int unsigned N_ROWS = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              dir_i,
  input  logic              pol_i,
  input  logic              en_i,
  output logic              dout_o,
  output logic [N_ROWS-1:0] drv_en_o,
  output logic [N_ROWS-1:0] lvl_o
);
  logic                fall;
  logic [N_ROWS-1:0]   shift_q;
  rdc_pkg::shift_dir_e dir;

  assign dir = rdc_pkg::shift_dir_e'(dir_i);

  rdc_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fall_o (fall)
  );

  rdc_shift_reg #(.N_ROWS(N_ROWS)) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (fall),
    .dir_i   (dir),
    .din_i   (din_i),
    .q_o     (shift_q)
  );

  rdc_out_stage #(.N_ROWS(N_ROWS)) u_out (
    .q_i      (shift_q),
    .dir_i    (dir),
    .pol_i    (pol_i),
    .en_i     (en_i),
    .dout_o   (dout_o),
    .drv_en_o (drv_en_o),
    .lvl_o    (lvl_o)
  );
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int unsigned N_ROWS = 34
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              din_i,
  input logic              dir_i,
  input logic              pol_i,
  input logic              en_i,
  input logic [N_ROWS-1:0] q_i,
  input logic [N_ROWS-1:0] drv_en_o,
  input logic [N_ROWS-1:0] lvl_o
);
  // reset clears the register (R1)
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r1: assert (q_i == '0);
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i || !$past(sclk_i)) |=> $stable(q_i));

  p_shift_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sclk_i) && !sclk_i && !dir_i)
      |=> (q_i == {$past(q_i[N_ROWS-2:0]), $past(din_i)}));

  p_shift_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sclk_i) && !sclk_i && dir_i)
      |=> (q_i == {$past(din_i), $past(q_i[N_ROWS-1:1])}));

  p_float_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o & ~q_i) == '0);

  p_level_pol_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o != '0) |-> ((drv_en_o & (lvl_o ^ {N_ROWS{pol_i}})) == '0));

  p_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (drv_en_o == '0));
endmodule

bind row_drv_core rdc_checker #(.N_ROWS(N_ROWS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_i   (sclk_i),
  .din_i    (din_i),
  .dir_i    (dir_i),
  .pol_i    (pol_i),
  .en_i     (en_i),
  .q_i      (shift_q),
  .drv_en_o (drv_en_o),
  .lvl_o    (lvl_o)
);

// File: tb/row_drv_core_test.sv
module row_drv_core_test;
  localparam int N = 34;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, din, dir, pol, en;
  logic dout;
  logic [N-1:0] drv, lvl;
  logic [N-1:0] mq;
  int checks = 0;
  int fails  = 0;

  row_drv_core #(.N_ROWS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .din_i(din),
    .dir_i(dir), .pol_i(pol), .en_i(en),
    .dout_o(dout), .drv_en_o(drv), .lvl_o(lvl)
  );

  task automatic check(input string tag);
    logic [N-1:0] e_drv;
    logic [N-1:0] e_lvl;
    logic         e_dout;
    e_drv  = en ? mq : '0;
    e_lvl  = {N{pol}};
    e_dout = dir ? mq[0] : mq[N-1];
    checks++;
    if (drv !== e_drv || lvl !== e_lvl || dout !== e_dout) begin
      fails++;
      $display("FAIL %s: drv=%h lvl=%h dout=%b expected drv=%h lvl=%h dout=%b",
               tag, drv, lvl, dout, e_drv, e_lvl, e_dout);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk);
    din  = b;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    if (dir) mq = {b, mq[N-1:1]};
    else     mq = {mq[N-2:0], b};
    din = ~b;
    @(negedge clk);
  endtask

  function automatic logic pat(input int i);
    return ((i * 7 + 3) % 5) < 2;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; din = 1'b1; dir = 1'b0; pol = 1'b1; en = 1'b1;
    mq = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release");

    // up shift over full length plus a few
    dir = 1'b0;
    for (int i = 0; i < N + 4; i++) begin
      pulse(pat(i));
      check("R3 R5 R6 up shift");
    end

    // no falling edge: hold under data activity
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); din = ~din;
    end
    check("R2 sclk held low");
    sclk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); din = ~din;
    end
    check("R2 sclk held high");

    // tap swap with no shift
    dir = 1'b1; @(negedge clk);
    check("R5 tap to row 0");
    dir = 1'b0; @(negedge clk);
    check("R5 tap to last row");

    // down shift
    dir = 1'b1;
    for (int i = 0; i < N + 6; i++) begin
      pulse(pat(i + 11) ^ i[0]);
      check("R4 R5 down shift");
    end

    // enable and polarity sweep
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      en  = c[1];
      pol = c[0];
      @(negedge clk);
      if (en) check("R6 enable/polarity sweep");
      else    check("R7 enable/polarity sweep");
    end

    // shifting with enable low, then re-enable
    en = 1'b0; pol = 1'b0;
    for (int i = 0; i < 5; i++) begin
      pulse(i[0]);
      check("R7 shift while disabled");
    end
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    check("R7 pattern back on enable");
    pol = 1'b1; @(negedge clk);
    check("R6 polarity high after enable");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule